// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries fixed-width data words from a producer clocked by one clock to a consumer clocked by a second, unrelated clock, without losing or repeating a word. The two clocks may have any phase and frequency relation. Storage is a memory array of `DEPTH` words, written in the write clock domain and read in the read clock domain.

Each side keeps its own pointer, one bit wider than the address. Each pointer is held both as a binary count and as a gray code. Only the gray form goes to the other domain. It passes through two back-to-back flip-flops there and is converted back to binary. Because a gray count changes in one bit per step, a sample taken while an edge is close to a pointer change gives either the old or the new value, never a mixture.

The write side raises a full flag and the read side raises an empty flag. Both flags are registered. A write attempted while full, or a read attempted while empty, is dropped. `DEPTH` must be a power of two, at least 4. Each side has its own asynchronous, active-low reset.

Top module: `xfifo_dc`

## Requirements
- R1: After `wrst_n` has been low, `wr_full` is 0. After `rrst_n` has been low, `rd_empty` is 1 and `rd_data` is 0.
- R2: Every word accepted on the write side is delivered exactly once on the read side, in the order written.
- R3: A write with `wr_en` high while `wr_full` is 1 is ignored. No word is stored and the write pointer does not advance.
- R4: A read with `rd_en` high while `rd_empty` is 1 is ignored. `rd_data` holds its value and the read pointer does not advance.
- R5: On a `rclk` edge where `rd_en` is 1 and `rd_empty` is 0, `rd_data` takes the next stored word. It is valid right after that edge. On any other `rclk` edge `rd_data` holds.
- R6: Each gray pointer sent to the other domain changes in at most one bit per edge of its own clock.
- R7: Consider writes with the read side idle and the read pointer already synchronized. `wr_full` rises on the `wclk` edge that accepts the DEPTH-th stored word. Once the read side has drained and gone idle, `wr_full` is 0 again.
- R8: Consider reads with the write side idle and the write pointer already synchronized. `rd_empty` rises on the `rclk` edge that takes the last stored word. After the write side goes idle and a few `rclk` cycles pass, `rd_empty` is 1 exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write domain clock |
| wrst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No free slot; writes are dropped |
| rclk | input | 1 | Read domain clock |
| rrst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Word taken by the last accepted read |
| rd_empty | output | 1 | No stored word visible; reads are dropped |

## Verification
The bench first fills the FIFO with the read side idle and keeps writing past full, then drains it with the write side idle and keeps reading past empty. This is the only pattern in which the flag edges can be predicted exactly. It separates correct full and empty timing from off-by-one faults, and it shows whether dropped requests are truly ignored. Concurrent streams follow with a slow writer against a fast reader, and then a fast writer against a slow reader. These keep the FIFO near empty in one case and near full in the other, so any lost or repeated word shows up when the delivered order is compared. A partial fill left at rest checks that both flags settle to the true occupancy.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

  // Binary count to reflected gray code.
  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary: each bit is the XOR of all gray bits at or above it.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  // Two plain flops, nothing between them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/xfifo_wptr.sv
`timescale 1ns/1ps
module xfifo_wptr
  import xfifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        wr_en,
  input  logic [AW:0] rq2_gray,
  output logic        full,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        push
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [AW:0] wbin, wbin_nx, wgray_nx, full_pat, rq2_bin, w_level;

  assign push     = wr_en & ~full;
  assign wbin_nx  = wbin + PW'(push);
  assign wgray_nx = PW'(bin_to_gray(32'(wbin_nx)));
  // Full: the other pointer is one lap behind, so its top two gray bits are inverted.
  assign full_pat = {~rq2_gray[AW:AW-1], rq2_gray[AW-2:0]};
  assign rq2_bin  = PW'(gray_to_bin(32'(rq2_gray)));
  assign w_level  = wbin - rq2_bin;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == full_pat);
    end
  end

  a_r3_full_write_ignored: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wr_en) |=> $stable(wbin));

  a_r6_wgray_one_bit: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r7_no_overrun: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_level <= PW'(DEPTH));

endmodule

// File: rtl/xfifo_rptr.sv
`timescale 1ns/1ps
module xfifo_rptr
  import xfifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        rd_en,
  input  logic [AW:0] wq2_gray,
  output logic        empty,
  output logic [AW:0] rgray,
  output logic [AW-1:0] raddr,
  output logic        pop
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [AW:0] rbin, rbin_nx, rgray_nx, wq2_bin, r_level;

  assign pop      = rd_en & ~empty;
  assign rbin_nx  = rbin + PW'(pop);
  assign rgray_nx = PW'(bin_to_gray(32'(rbin_nx)));
  assign wq2_bin  = PW'(gray_to_bin(32'(wq2_gray)));
  assign r_level  = wq2_bin - rbin;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wq2_gray);
    end
  end

  a_r4_empty_read_ignored: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && rd_en) |=> $stable(rbin));

  a_r6_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  a_r8_no_underrun: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_level <= PW'(DEPTH));

endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          push,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (push) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (pop) rdata <= ram[raddr];
  end

  a_r5_data_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    !pop |=> $stable(rdata));

endmodule

// File: rtl/xfifo_dc.sv
`timescale 1ns/1ps
module xfifo_dc #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty
);

  localparam int AW = $clog2(DEPTH);

  logic [AW:0]   wgray, rgray, wq2_gray, rq2_gray;
  logic [AW-1:0] waddr, raddr;
  logic          push, pop;

  initial begin
    a_depth_ok: assert (DEPTH >= 4 && (1 << AW) == DEPTH);
  end

  xfifo_wptr #(.AW(AW)) u_wptr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rq2_gray(rq2_gray),
    .full(wr_full), .wgray(wgray), .waddr(waddr), .push(push)
  );

  xfifo_rptr #(.AW(AW)) u_rptr (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wq2_gray(wq2_gray),
    .empty(rd_empty), .rgray(rgray), .raddr(raddr), .pop(pop)
  );

  xfifo_sync #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq2_gray)
  );

  xfifo_sync #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq2_gray)
  );

  xfifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .push(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .pop(pop), .raddr(raddr), .rdata(rd_data)
  );

  a_r1_full_low_after_reset: assert property (@(posedge wclk)
    !wrst_n |=> !wr_full);

  a_r1_empty_after_reset: assert property (@(posedge rclk)
    !rrst_n |=> rd_empty);

endmodule

// File: tb/xfifo_dc_bench.sv
`timescale 1ns/1ps
module xfifo_dc_bench;

  localparam int DW    = 8;
  localparam int DEPTH = 8;

  logic          wclk = 0, rclk = 0;
  logic          wrst_n = 0, rrst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_full, rd_empty;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] next_val = 8'h01;
  logic [DW-1:0] last_rd = '0;
  bit done = 0;

  always #2   wclk = ~wclk;   // 250 MHz write clock
  always #3.5 rclk = ~rclk;   // unrelated read clock

  xfifo_dc #(.DW(DW), .DEPTH(DEPTH)) u_xfifo_dc (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Writer: tries until target accepted or max attempts. exact: read side idle.
  task automatic write_run(input int target, input int max_att, input int duty,
                           input bit exact, output int acc);
    int att = 0;
    acc = 0;
    while (acc < target && att < max_att) begin
      @(negedge wclk);
      if (exact) chk(wr_full == (model.size() == DEPTH), "R7 full edge", wr_full,
                     model.size() == DEPTH);
      wr_en = ($urandom_range(99) < duty);
      if (wr_en) begin
        att++;
        wr_data = next_val;
        if (!wr_full) begin          // R3: dropped when full
          model.push_back(next_val);
          next_val = next_val + 1'b1;
          acc++;
        end
      end
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  // Reader: compares rd_data every rclk cycle against the model.
  task automatic read_run(input int target, input int max_att, input int duty,
                          input bit exact, output int got);
    int att = 0;
    bit pend = 0;
    logic [DW-1:0] exp_w = '0;
    got = 0;
    while (got < target && att < max_att) begin
      @(negedge rclk);
      if (pend) begin
        chk(rd_data == exp_w, "R2 R5 read word", rd_data, exp_w);
        last_rd = rd_data;
      end else begin
        chk(rd_data == last_rd, "R4 R5 data holds", rd_data, last_rd);
      end
      pend = 0;
      if (exact) chk(rd_empty == (model.size() == 0), "R8 empty edge", rd_empty,
                     model.size() == 0);
      rd_en = ($urandom_range(99) < duty);
      if (rd_en) begin
        att++;
        if (!rd_empty) begin
          if (model.size() == 0) begin
            chk(0, "R2 read with nothing written", 0, 1);
          end else begin
            exp_w = model.pop_front();
            pend  = 1;
            got++;
          end
        end
      end
    end
    @(negedge rclk);
    rd_en = 0;
    if (pend) begin
      chk(rd_data == exp_w, "R2 R5 last read word", rd_data, exp_w);
      last_rd = rd_data;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
    repeat (12) @(negedge wclk);
  endtask

  initial begin
    int n, m;
    repeat (3) @(negedge wclk);
    @(negedge rclk);
    chk(rd_empty == 1, "R1 empty in reset", rd_empty, 1);
    chk(wr_full == 0, "R1 full in reset", wr_full, 0);
    wrst_n = 1;
    rrst_n = 1;
    @(negedge rclk);
    chk(rd_data == 0, "R1 rd_data reset", rd_data, 0);
    chk(rd_empty == 1, "R1 empty after reset", rd_empty, 1);
    settle();

    // Fill past full with reads idle (R3, R7).
    write_run(DEPTH + 4, DEPTH + 4, 100, 1, n);
    chk(n == DEPTH, "R3 accepted count", n, DEPTH);
    @(negedge wclk);
    chk(wr_full == 1, "R7 full held", wr_full, 1);
    settle();
    // Drain past empty with writes idle (R4, R8).
    read_run(DEPTH, DEPTH + 3, 100, 1, m);
    chk(m == DEPTH, "R2 drained count", m, DEPTH);
    read_run(1, 3, 100, 1, m);
    chk(m == 0, "R4 read while empty", m, 0);
    settle();
    chk(wr_full == 0, "R7 full clears", wr_full, 0);

    // Slow writer, fast reader.
    fork
      write_run(150, 100000, 35, 0, n);
      read_run(150, 100000, 100, 0, m);
    join
    chk(m == 150, "R2 stream1 count", m, 150);
    settle();
    chk(rd_empty == 1, "R8 rest empty", rd_empty, 1);
    chk(model.size() == 0, "R2 model drained", model.size(), 0);

    // Fast writer, slow reader.
    fork
      write_run(150, 100000, 100, 0, n);
      read_run(150, 100000, 25, 0, m);
    join
    chk(m == 150, "R2 stream2 count", m, 150);
    settle();
    chk(rd_empty == 1 && wr_full == 0, "R7 R8 rest flags", {rd_empty, wr_full}, 2);

    // Partial fill at rest.
    write_run(5, 5, 100, 0, n);
    settle();
    chk(rd_empty == 0, "R8 partial not empty", rd_empty, 0);
    chk(wr_full == 0, "R7 partial not full", wr_full, 0);
    read_run(5, 100, 60, 0, m);
    settle();
    chk(rd_empty == 1, "R8 partial drained", rd_empty, 1);

    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      summary();
    end
  end

endmodule